// File: doc/BRIEF.md
# GPIO Edge Interrupt Status Controller

This block watches a parameterised group of GPIO input lines and turns their edges into interrupt status. Each line has an enable bit and a polarity bit. The polarity bit picks which edge counts as the "assert" event. The opposite edge is the "deassert" event. The two kinds of event are latched into two separate status banks. Each bank drives its own level interrupt line, so software can service assert and deassert events on separate vectors.

Software reaches the block through a single-cycle word write port and a combinational word read port. A 2-bit kind field selects one of four register kinds. The enable and polarity words hold 32 lines each. Each status word holds 31 lines in bits 1 to 31. Bit 0 of a written status word is a mode bit that chooses how the other bits act. With bit 0 low, each one bit written clears that status bit. With bit 0 high, each one bit written sets it. The input lines are expected to be synchronised already.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: After reset, every enable, polarity and status bit is 0, both interrupt outputs are low, and every read returns 0.
- R2: Kind codes are enable=0, polarity=1, assert status=2, deassert status=3. Line p sits in enable/polarity word p/32 at bit p mod 32. It sits in status word p/31 at bit (p mod 31)+1.
- R3: With polarity 1, a rising edge sets the line's assert status bit and a falling edge sets its deassert status bit.
- R4: With polarity 0, a falling edge sets the assert status bit and a rising edge sets the deassert status bit.
- R5: An edge on a line whose enable bit is 0 changes no status bit.
- R6: A status write with bit 0 = 0 clears exactly the bits written as 1 and leaves the others unchanged.
- R7: A status write with bit 0 = 1 sets exactly the bits written as 1.
- R8: Status bit 0 always reads 0. Bits of enable, polarity or status words that map to no existing line read 0.
- R9: If an edge and a clear write reach the same status bit in the same cycle, the bit ends up set.
- R10: Each interrupt output is high exactly while at least one bit of its own bank is set. The two banks are independent.
- R11: An edge is compared against the line's level one cycle earlier. The status bit reads set after the first clock edge that samples the new level, and it holds until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Synchronised GPIO input levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Register kind of the write |
| wr_idx_i | input | IDX_W | Word index of the write |
| wr_data_i | input | 32 | Write data |
| rd_kind_i | input | 2 | Register kind of the read |
| rd_idx_i | input | IDX_W | Word index of the read |
| rd_data_o | output | 32 | Read data, combinational |
| irq_assert_o | output | 1 | Level interrupt, OR of the assert bank |
| irq_deassert_o | output | 1 | Level interrupt, OR of the deassert bank |

## Verification
The bench builds the block with 60 lines and the registered interrupt variant. The count of 60 spans two status words and two configuration words and fills neither second word completely. That reaches the 31-versus-32 packing boundary at lines 30 and 31, the last line 59, and the read-as-zero bits above it in both layouts. The registered interrupt variant shows that the interrupt outputs still follow status in the same cycle.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;

   typedef enum logic [1:0] {
      REG_ENABLE        = 2'd0,
      REG_POLARITY      = 2'd1,
      REG_STAT_ASSERT   = 2'd2,
      REG_STAT_DEASSERT = 2'd3
   } gpio_reg_kind_e;

   localparam int unsigned STAT_LINES_PER_WORD = 31;
   localparam int unsigned CFG_LINES_PER_WORD  = 32;
   localparam int unsigned BUS_W               = 32;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/gpio_eirq_cfg.sv
module gpio_eirq_cfg
   import gpio_eirq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 62,
   parameter int unsigned IDX_W    = 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  logic                wr_pol_i,
   input  logic [IDX_W-1:0]    wr_idx_i,
   input  logic [BUS_W-1:0]    wr_data_i,
   output logic [NUM_PINS-1:0] enable_o,
   output logic [NUM_PINS-1:0] polarity_o
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_line
      localparam int unsigned WORD = p / CFG_LINES_PER_WORD;
      localparam int unsigned BITN = p % CFG_LINES_PER_WORD;
      logic hit;
      assign hit = wr_en_i && (wr_idx_i == IDX_W'(WORD));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            enable_o[p]   <= 1'b0;
            polarity_o[p] <= 1'b0;
         end else if (hit) begin
            if (wr_pol_i) polarity_o[p] <= wr_data_i[BITN];
            else          enable_o[p]   <= wr_data_i[BITN];
         end
      end
   end

endmodule

// File: rtl/gpio_eirq_edge.sv
module gpio_eirq_edge #(
   parameter int unsigned NUM_PINS = 62
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic [NUM_PINS-1:0] enable_i,
   input  logic [NUM_PINS-1:0] polarity_i,
   output logic [NUM_PINS-1:0] asrt_evt_o,
   output logic [NUM_PINS-1:0] dasrt_evt_o
);

   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] rise;
   logic [NUM_PINS-1:0] fall;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= pin_i;
   end

   assign rise = pin_i & ~prev_q;
   assign fall = ~pin_i & prev_q;

   // polarity 1: rising edge asserts; polarity 0: falling edge asserts
   assign asrt_evt_o  = enable_i & ((polarity_i & rise) | (~polarity_i & fall));
   assign dasrt_evt_o = enable_i & ((polarity_i & fall) | (~polarity_i & rise));

endmodule

// File: rtl/gpio_eirq_bank.sv
module gpio_eirq_bank
   import gpio_eirq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 62,
   parameter int unsigned IDX_W    = 1,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PINS-1:0] evt_i,
   input  logic                wr_en_i,
   input  logic [IDX_W-1:0]    wr_idx_i,
   input  logic [BUS_W-1:0]    wr_data_i,
   output logic [NUM_PINS-1:0] status_o,
   output logic                irq_o
);

   logic [NUM_PINS-1:0] status_d;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_line
      localparam int unsigned WORD = p / STAT_LINES_PER_WORD;
      localparam int unsigned BITN = (p % STAT_LINES_PER_WORD) + 1;
      logic sel;
      assign sel = wr_en_i && (wr_idx_i == IDX_W'(WORD)) && wr_data_i[BITN];

      // a new edge outranks a software clear in the same cycle
      always_comb begin
         if (evt_i[p] || (sel && wr_data_i[0])) status_d[p] = 1'b1;
         else if (sel)                          status_d[p] = 1'b0;
         else                                   status_d[p] = status_o[p];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) status_o[p] <= 1'b0;
         else         status_o[p] <= status_d[p];
      end
   end

   if (IRQ_REG) begin : g_irq_reg
      // flop fed from next-state so the line tracks status with no extra cycle
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_o <= 1'b0;
         else         irq_o <= |status_d;
      end
   end else begin : g_irq_comb
      assign irq_o = |status_o;
   end

endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl
   import gpio_eirq_pkg::*;
#(
   parameter int unsigned  NUM_PINS = 62,
   parameter bit           IRQ_REG  = 1'b0,
   localparam int unsigned STAT_WORDS = ceil_div(NUM_PINS, STAT_LINES_PER_WORD),
   localparam int unsigned IDX_W      = (STAT_WORDS > 1) ? $clog2(STAT_WORDS) : 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                wr_en_i,
   input  logic [1:0]          wr_kind_i,
   input  logic [IDX_W-1:0]    wr_idx_i,
   input  logic [31:0]         wr_data_i,
   input  logic [1:0]          rd_kind_i,
   input  logic [IDX_W-1:0]    rd_idx_i,
   output logic [31:0]         rd_data_o,
   output logic                irq_assert_o,
   output logic                irq_deassert_o
);

   if (NUM_PINS < 1 || NUM_PINS > 992) begin : g_bad_num_pins
      $error("gpio_edge_irq_ctrl: NUM_PINS must lie in 1..992");
   end

   gpio_reg_kind_e wr_kind, rd_kind;
   assign wr_kind = gpio_reg_kind_e'(wr_kind_i);
   assign rd_kind = gpio_reg_kind_e'(rd_kind_i);

   logic [NUM_PINS-1:0] en_q, pol_q;
   logic [NUM_PINS-1:0] asrt_evt, dasrt_evt;
   logic [NUM_PINS-1:0] asrt_stat, dasrt_stat;
   logic                cfg_wr, asrt_wr, dasrt_wr;

   assign cfg_wr   = wr_en_i && (wr_kind == REG_ENABLE || wr_kind == REG_POLARITY);
   assign asrt_wr  = wr_en_i && (wr_kind == REG_STAT_ASSERT);
   assign dasrt_wr = wr_en_i && (wr_kind == REG_STAT_DEASSERT);

   gpio_eirq_cfg #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (cfg_wr),
      .wr_pol_i   (wr_kind == REG_POLARITY),
      .wr_idx_i   (wr_idx_i),
      .wr_data_i  (wr_data_i),
      .enable_o   (en_q),
      .polarity_o (pol_q)
   );

   gpio_eirq_edge #(.NUM_PINS(NUM_PINS)) u_edge (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_i       (pin_i),
      .enable_i    (en_q),
      .polarity_i  (pol_q),
      .asrt_evt_o  (asrt_evt),
      .dasrt_evt_o (dasrt_evt)
   );

   gpio_eirq_bank #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .IRQ_REG(IRQ_REG)) u_asrt_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (asrt_evt),
      .wr_en_i   (asrt_wr),
      .wr_idx_i  (wr_idx_i),
      .wr_data_i (wr_data_i),
      .status_o  (asrt_stat),
      .irq_o     (irq_assert_o)
   );

   gpio_eirq_bank #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .IRQ_REG(IRQ_REG)) u_dasrt_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (dasrt_evt),
      .wr_en_i   (dasrt_wr),
      .wr_idx_i  (wr_idx_i),
      .wr_data_i (wr_data_i),
      .status_o  (dasrt_stat),
      .irq_o     (irq_deassert_o)
   );

   // read mux: configuration words pack 32 lines, status words 31 lines above bit 0
   always_comb begin
      rd_data_o = '0;
      for (int b = 0; b < 32; b++) begin
         int unsigned cp;
         int unsigned sp;
         cp = int'(rd_idx_i) * CFG_LINES_PER_WORD + b;
         sp = int'(rd_idx_i) * STAT_LINES_PER_WORD + b - 1;
         case (rd_kind)
            REG_ENABLE:        if (cp < NUM_PINS) rd_data_o[b] = en_q[cp];
            REG_POLARITY:      if (cp < NUM_PINS) rd_data_o[b] = pol_q[cp];
            REG_STAT_ASSERT:   if (b > 0 && sp < NUM_PINS) rd_data_o[b] = asrt_stat[sp];
            REG_STAT_DEASSERT: if (b > 0 && sp < NUM_PINS) rd_data_o[b] = dasrt_stat[sp];
            default:           rd_data_o[b] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_eirq_chk.sv
module gpio_eirq_chk
   import gpio_eirq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 62
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                wr_en_i,
   input logic [1:0]          wr_kind_i,
   input logic [31:0]         wr_data_i,
   input logic [NUM_PINS-1:0] en_q,
   input logic [NUM_PINS-1:0] asrt_evt,
   input logic [NUM_PINS-1:0] dasrt_evt,
   input logic [NUM_PINS-1:0] asrt_stat,
   input logic [NUM_PINS-1:0] dasrt_stat,
   input logic                irq_assert_o,
   input logic                irq_deassert_o
);

   logic a_wr, d_wr;
   assign a_wr = wr_en_i && (wr_kind_i == REG_STAT_ASSERT);
   assign d_wr = wr_en_i && (wr_kind_i == REG_STAT_DEASSERT);

   assert_evt_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((asrt_evt | dasrt_evt) & ~en_q) == '0);

   // R3 and R4: a line's edge is either its assert or its deassert event, never both
   assert_evt_disjoint_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (asrt_evt & dasrt_evt) == '0);

   assert_edge_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|asrt_evt) |=> ((asrt_stat & $past(asrt_evt)) == $past(asrt_evt)));

   assert_edge_wins_dasrt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|dasrt_evt) |=> ((dasrt_stat & $past(dasrt_evt)) == $past(dasrt_evt)));

   assert_irq_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_assert_o) |-> $past((|asrt_evt) || (a_wr && wr_data_i[0])));

   assert_irq_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_assert_o) |-> $past(a_wr && !wr_data_i[0]));

   assert_irq_fall_dasrt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_deassert_o) |-> $past(d_wr && !wr_data_i[0]));

   assert_status_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!a_wr && asrt_evt == '0) |=> (asrt_stat == $past(asrt_stat)));

   assert_status_hold_dasrt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!d_wr && dasrt_evt == '0) |=> (dasrt_stat == $past(dasrt_stat)));

endmodule

bind gpio_edge_irq_ctrl gpio_eirq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .wr_en_i        (wr_en_i),
   .wr_kind_i      (wr_kind_i),
   .wr_data_i      (wr_data_i),
   .en_q           (en_q),
   .asrt_evt       (asrt_evt),
   .dasrt_evt      (dasrt_evt),
   .asrt_stat      (asrt_stat),
   .dasrt_stat     (dasrt_stat),
   .irq_assert_o   (irq_assert_o),
   .irq_deassert_o (irq_deassert_o)
);

// File: tb/gpio_edge_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_edge_irq_ctrl_bench;

   localparam int unsigned NP = 60;
   localparam logic [1:0] K_EN = 2'd0, K_POL = 2'd1, K_A = 2'd2, K_D = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NP-1:0] pins = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_kind = '0;
   logic [0:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_kind = '0;
   logic [0:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic        irq_a, irq_d;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_edge_irq_ctrl #(.NUM_PINS(NP), .IRQ_REG(1'b1)) u_gpio_edge_irq_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .pin_i(pins),
      .wr_en_i(wr_en), .wr_kind_i(wr_kind), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
      .rd_kind_i(rd_kind), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
      .irq_assert_o(irq_a), .irq_deassert_o(irq_d)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(input string tag, input logic [1:0] k, input int i, input logic [31:0] exp);
      rd_kind = k;
      rd_idx  = 1'(i);
      #0.3;
      check(tag, rd_data, exp);
   endtask

   task automatic wr(input logic [1:0] k, input int i, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_kind = k; wr_idx = 1'(i); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic drive_pins(input logic [NP-1:0] v);
      @(negedge clk);
      pins = v;
      @(negedge clk);
   endtask

   task automatic clear_all();
      for (int i = 0; i < 2; i++) begin
         wr(K_A, i, 32'hFFFF_FFFE);
         wr(K_D, i, 32'hFFFF_FFFE);
      end
   endtask

   task automatic t_reset();
      for (int k = 0; k < 4; k++)
         for (int i = 0; i < 2; i++)
            rd_chk("R1 reset read", 2'(k), i, 32'h0);
      check("R1 reset irq_assert", {31'h0, irq_a}, 32'h0);
      check("R1 reset irq_deassert", {31'h0, irq_d}, 32'h0);
   endtask

   task automatic t_cfg_map();
      wr(K_EN, 1, 32'hFFFF_FFFF);
      rd_chk("R8 enable word1 above last line", K_EN, 1, 32'h0FFF_FFFF);
      wr(K_POL, 0, 32'h1234_5678);
      rd_chk("R2 polarity word0 readback", K_POL, 0, 32'h1234_5678);
   endtask

   task automatic t_pol_high();
      // lines 0,30,31,59 enabled with polarity 1
      wr(K_EN, 0, 32'hC000_0001);  wr(K_EN, 1, 32'h0800_0000);
      wr(K_POL, 0, 32'hC000_0001); wr(K_POL, 1, 32'h0800_0000);
      drive_pins(NP'(1) | (NP'(1) << 30) | (NP'(1) << 31) | (NP'(1) << 59));
      rd_chk("R2 R3 assert word0 after rise", K_A, 0, 32'h8000_0002);
      rd_chk("R2 R3 assert word1 after rise", K_A, 1, 32'h2000_0002);
      rd_chk("R3 deassert word0 after rise", K_D, 0, 32'h0);
      check("R10 irq_assert high", {31'h0, irq_a}, 32'h1);
      check("R10 irq_deassert low", {31'h0, irq_d}, 32'h0);
      repeat (3) @(negedge clk);
      rd_chk("R11 assert word0 holds", K_A, 0, 32'h8000_0002);
      drive_pins('0);
      rd_chk("R3 deassert word0 after fall", K_D, 0, 32'h8000_0002);
      rd_chk("R3 deassert word1 after fall", K_D, 1, 32'h2000_0002);
      rd_chk("R11 assert word1 unchanged", K_A, 1, 32'h2000_0002);
      wr(K_A, 0, 32'h8000_0002);
      wr(K_A, 1, 32'h2000_0002);
      rd_chk("R6 assert word0 cleared", K_A, 0, 32'h0);
      rd_chk("R6 assert word1 cleared", K_A, 1, 32'h0);
      check("R10 irq_assert low after clear", {31'h0, irq_a}, 32'h0);
      check("R10 irq_deassert still high", {31'h0, irq_d}, 32'h1);
      wr(K_D, 1, 32'h0000_0002);
      rd_chk("R6 partial clear keeps others", K_D, 1, 32'h2000_0000);
      clear_all();
   endtask

   task automatic t_pol_low();
      wr(K_EN, 0, 32'hC000_0021);
      wr(K_POL, 0, 32'hC000_0001);
      drive_pins(NP'(1) << 5);
      rd_chk("R4 deassert on rise", K_D, 0, 32'h0000_0040);
      rd_chk("R4 no assert on rise", K_A, 0, 32'h0);
      drive_pins('0);
      rd_chk("R4 assert on fall", K_A, 0, 32'h0000_0040);
      clear_all();
   endtask

   task automatic t_disabled();
      wr(K_EN, 0, 32'h0);
      drive_pins((NP'(1) << 10) | NP'(1));
      drive_pins('0);
      rd_chk("R5 assert word0 untouched", K_A, 0, 32'h0);
      rd_chk("R5 deassert word0 untouched", K_D, 0, 32'h0);
      check("R5 irq_assert low", {31'h0, irq_a}, 32'h0);
      check("R5 irq_deassert low", {31'h0, irq_d}, 32'h0);
   endtask

   task automatic t_sw_set();
      wr(K_A, 1, 32'h0000_0011);
      rd_chk("R7 set one bit", K_A, 1, 32'h0000_0010);
      check("R10 irq_assert after set", {31'h0, irq_a}, 32'h1);
      wr(K_A, 1, 32'hFFFF_FFFF);
      rd_chk("R8 set all reads bit0 and spare bits zero", K_A, 1, 32'h3FFF_FFFE);
      wr(K_A, 1, 32'hFFFF_FFFE);
      rd_chk("R6 clear all of word1", K_A, 1, 32'h0);
      check("R10 irq_assert low again", {31'h0, irq_a}, 32'h0);
      wr(K_D, 0, 32'h0000_0003);
      rd_chk("R7 deassert set", K_D, 0, 32'h0000_0002);
      check("R10 irq_deassert from set", {31'h0, irq_d}, 32'h1);
      clear_all();
   endtask

   task automatic t_edge_wins();
      wr(K_EN, 0, 32'h1);
      wr(K_POL, 0, 32'h1);
      @(negedge clk);
      pins[0] = 1'b1;
      wr_en = 1'b1; wr_kind = K_A; wr_idx = 1'b0; wr_data = 32'h0000_0002;
      @(negedge clk);
      wr_en = 1'b0;
      rd_chk("R9 edge beats clear", K_A, 0, 32'h0000_0002);
      check("R9 irq_assert stays high", {31'h0, irq_a}, 32'h1);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_map();
      t_pol_high();
      t_pol_low();
      t_disabled();
      t_sw_set();
      t_edge_wins();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule